// File: doc/BRIEF.md
# Command frame receiver

This block sits behind a serial slave port that delivers 16-bit words and turns that word stream into complete commands. The first word of each command is a header: its upper four bits name the operation and its lower twelve bits give the command's total size in 16-bit words, header included. The receiver reads exactly that many further words, keeps the argument words in a local buffer, and hands the complete command to a downstream executor over a valid/ready handshake. The executor reads the arguments through a random-access read port.

The receiver checks two things: whether the opcode is in a fixed supported set, and whether the size is legal. It never inspects argument data. Once a command has been handled, one response word waits for the host to clock it out. That word is either an acknowledge, after the executor has accepted the command, or a negative acknowledge when the opcode is unsupported, the size is zero, or the arguments would overflow the buffer. While a command is with the executor or a response is waiting, the block reports busy and ignores any incoming word.

Top module: `cmd_frame_rx`

## Requirements
- R1: After a synchronous active-low reset, and after a reset that arrives in the middle of a command, `busy`, `cmd_valid` and `rsp_valid` are 0, and the next word accepted is treated as a header.
- R2: A header word carries the opcode in bits 15:12 and the total length in bits 11:0. While `cmd_valid` is high, `cmd_opcode` and `cmd_len` show those fields.
- R3: A header with length N (N ≥ 1) is followed by exactly N−1 argument words. `cmd_valid` rises on the clock edge after the last argument word is accepted, or on the edge after the header when N = 1.
- R4: Argument words appear unchanged on `cmd_rd_data` at `cmd_rd_idx` = k for the k-th argument word, counting from 0, in arrival order.
- R5: When `cmd_valid` and `cmd_ready` are both high at a clock edge, `rsp_valid` rises on that edge with `rsp_word` = {4'h1, opcode, 8'h00} (acknowledge).
- R6: An opcode whose bit in `OP_MASK` is 0 never raises `cmd_valid`. With the default mask, opcodes 8 to 15 are unsupported. The N−1 argument words are still consumed, and then `rsp_word` = {4'h2, opcode, 8'h00} (negative acknowledge).
- R7: A header with length 0 consumes no further words and is answered at once with {4'h2, opcode, 8'h00}.
- R8: A length whose argument count N−1 exceeds `DEPTH` (64) is answered with negative acknowledge after all N−1 words have been consumed and discarded. N = 65 is still accepted.
- R9: While a command is offered to the executor or a response is pending, `busy` is 1 and `in_valid` words are ignored.
- R10: `rsp_valid` and `rsp_word` stay stable until `rsp_read` is sampled high. The block then waits for a new header.
- R11: `cmd_valid`, `cmd_opcode` and `cmd_len` stay stable until `cmd_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A received word is present this cycle |
| in_word | input | 16 | Received word from the serial port |
| busy | output | 1 | Command with executor or response pending; input ignored |
| cmd_valid | output | 1 | A complete, accepted command is offered |
| cmd_ready | input | 1 | Executor takes the offered command |
| cmd_opcode | output | 4 | Opcode of the offered command |
| cmd_len | output | 12 | Length field of the offered command, header included |
| cmd_rd_idx | input | 6 | Argument index to read |
| cmd_rd_data | output | 16 | Argument word at `cmd_rd_idx` |
| rsp_valid | output | 1 | Response word waiting for the host |
| rsp_word | output | 16 | Response: code in 15:12, echoed opcode in 11:8 |
| rsp_read | input | 1 | Host has clocked out the response |

## Verification
The assertions assume that the executor raises `cmd_ready` only while `cmd_valid` is high, and that the host raises `rsp_read` only while `rsp_valid` is high. The stimulus keeps to these rules because a single monitor process raises each strobe for exactly one cycle, and only after it has seen the matching valid. The stimulus also holds `cmd_ready` low for two cycles on every command, and after every command it sends a stray header word while the block is busy. This tests the stability and ignore rules under real back-pressure rather than leaving them unexercised.

// File: rtl/cmd_rx_pkg.sv
// Shared widths, state encoding and response codes for the command frame receiver.
package cmd_rx_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int LEN_W  = 12;

    localparam logic [3:0] CODE_ACK  = 4'h1;
    localparam logic [3:0] CODE_NACK = 4'h2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_EXEC,
        ST_RESP
    } rx_state_t;
endpackage

// File: rtl/cmd_hdr_decode.sv
// Splits a header word into opcode and length and classifies it.
// Assumes: the length counts the header itself; argument count is length-1.
module cmd_hdr_decode
    import cmd_rx_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter logic [15:0] OP_MASK = 16'h00FF
) (
    input  logic [WORD_W-1:0] word,
    output logic [OP_W-1:0]   opcode,
    output logic [LEN_W-1:0]  len,
    output logic              op_known,
    output logic              len_zero,
    output logic              len_fits
);
    // Field extraction and legality flags.
    always_comb begin
        opcode   = word[15:12];
        len      = word[11:0];
        op_known = OP_MASK[opcode];
        len_zero = (len == '0);
        len_fits = (len <= LEN_W'(DEPTH + 1));
    end
endmodule

// File: rtl/cmd_word_buf.sv
// Argument word store: one synchronous write port, one combinational read port.
// Assumes: the writer never addresses beyond DEPTH-1.
module cmd_word_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store an argument word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the selected argument.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/cmd_frame_ctrl.sv
// Framing state machine: header capture, argument count-down, executor
// handshake and response generation.
// Assumes: decode flags describe in_word in the current cycle.
module cmd_frame_ctrl
    import cmd_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   hdr_op,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              hdr_known,
    input  logic              hdr_zero,
    input  logic              hdr_fits,
    input  logic              cmd_ready,
    input  logic              rsp_read,
    output rx_state_t         state,
    output logic [OP_W-1:0]   op_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [WORD_W-1:0] rsp_q,
    output logic              buf_we,
    output logic [AW-1:0]     buf_waddr
);
    logic [LEN_W-1:0] remain;
    logic             ok_q;

    // Write strobe for argument words of a command that will be executed.
    always_comb begin
        buf_we    = (state == ST_COLLECT) && in_valid && ok_q;
        buf_waddr = wr_idx;
    end

    logic [AW-1:0] wr_idx;

    // Frame sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            len_q  <= '0;
            rsp_q  <= '0;
            remain <= '0;
            ok_q   <= 1'b0;
            wr_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    op_q   <= hdr_op;
                    len_q  <= hdr_len;
                    wr_idx <= '0;
                    remain <= hdr_len - LEN_W'(1);
                    ok_q   <= hdr_known && hdr_fits;
                    if (hdr_zero) begin
                        rsp_q <= {CODE_NACK, hdr_op, 8'h00};
                        state <= ST_RESP;
                    end else if (hdr_len == LEN_W'(1)) begin
                        if (hdr_known) begin
                            state <= ST_EXEC;
                        end else begin
                            rsp_q <= {CODE_NACK, hdr_op, 8'h00};
                            state <= ST_RESP;
                        end
                    end else begin
                        state <= ST_COLLECT;
                    end
                end
                ST_COLLECT: if (in_valid) begin
                    remain <= remain - LEN_W'(1);
                    if (ok_q) wr_idx <= wr_idx + AW'(1);
                    if (remain == LEN_W'(1)) begin
                        if (ok_q) begin
                            state <= ST_EXEC;
                        end else begin
                            rsp_q <= {CODE_NACK, op_q, 8'h00};
                            state <= ST_RESP;
                        end
                    end
                end
                ST_EXEC: if (cmd_ready) begin
                    rsp_q <= {CODE_ACK, op_q, 8'h00};
                    state <= ST_RESP;
                end
                ST_RESP: if (rsp_read) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_frame_rx.sv
// Top of the command frame receiver: decode, control and argument buffer.
// Assumes: one word per cycle at most on in_valid; executor and host
// strobes are raised only while the matching valid is high.
module cmd_frame_rx
    import cmd_rx_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter logic [15:0] OP_MASK = 16'h00FF,
    localparam int         AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              busy,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [OP_W-1:0]   cmd_opcode,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic [AW-1:0]     cmd_rd_idx,
    output logic [WORD_W-1:0] cmd_rd_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    input  logic              rsp_read
);
    logic [OP_W-1:0]  hdr_op;
    logic [LEN_W-1:0] hdr_len;
    logic             hdr_known, hdr_zero, hdr_fits;
    rx_state_t        state;
    logic [OP_W-1:0]  op_q;
    logic [LEN_W-1:0] len_q;
    logic [WORD_W-1:0] rsp_q;
    logic             buf_we;
    logic [AW-1:0]    buf_waddr;

    cmd_hdr_decode #(.DEPTH(DEPTH), .OP_MASK(OP_MASK)) u_dec (
        .word(in_word), .opcode(hdr_op), .len(hdr_len),
        .op_known(hdr_known), .len_zero(hdr_zero), .len_fits(hdr_fits)
    );

    cmd_frame_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hdr_op(hdr_op), .hdr_len(hdr_len), .hdr_known(hdr_known),
        .hdr_zero(hdr_zero), .hdr_fits(hdr_fits),
        .cmd_ready(cmd_ready), .rsp_read(rsp_read),
        .state(state), .op_q(op_q), .len_q(len_q), .rsp_q(rsp_q),
        .buf_we(buf_we), .buf_waddr(buf_waddr)
    );

    cmd_word_buf #(.DEPTH(DEPTH), .W(WORD_W)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(in_word),
        .raddr(cmd_rd_idx), .rdata(cmd_rd_data)
    );

    // Output view of the control state.
    always_comb begin
        cmd_valid  = (state == ST_EXEC);
        rsp_valid  = (state == ST_RESP);
        busy       = cmd_valid || rsp_valid;
        cmd_opcode = op_q;
        cmd_len    = len_q;
        rsp_word   = rsp_q;
    end
endmodule

// File: rtl/cmd_frame_rx_chk.sv
// Protocol checker for cmd_frame_rx, attached by bind.
// Assumes: cmd_ready only while cmd_valid, rsp_read only while rsp_valid.
module cmd_frame_rx_chk #(
    parameter int          DEPTH   = 64,
    parameter logic [15:0] OP_MASK = 16'h00FF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [3:0]  cmd_opcode,
    input logic [11:0] cmd_len,
    input logic        rsp_valid,
    input logic [15:0] rsp_word,
    input logic        rsp_read
);
    // R9
    busy_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cmd_valid || rsp_valid));

    // R9
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && rsp_valid));

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) && $stable(cmd_len));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_read |=> rsp_valid && $stable(rsp_word));

    // R5
    ack_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> rsp_valid && rsp_word[15:12] == 4'h1
            && rsp_word[11:8] == $past(cmd_opcode));

    // R6
    known_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> OP_MASK[cmd_opcode]);

    // R8
    legal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_len != 12'd0 && cmd_len <= 12'(DEPTH + 1));
endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(.DEPTH(DEPTH), .OP_MASK(OP_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cmd_len(cmd_len),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_read(rsp_read)
);

// File: tb/test_cmd_frame_rx.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver queues expected commands and responses,
// the monitor compares them as the design presents them.
module test_cmd_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        busy, cmd_valid, rsp_valid;
    logic        cmd_ready = 1'b0;
    logic [3:0]  cmd_opcode;
    logic [11:0] cmd_len;
    logic [5:0]  cmd_rd_idx = '0;
    logic [15:0] cmd_rd_data, rsp_word;
    logic        rsp_read = 1'b0;

    int checks = 0;
    int errors = 0;
    int rsp_seen = 0;

    logic [15:0] exp_rsp_q[$];
    logic [15:0] exp_hdr_q[$];
    logic [15:0] exp_data_q[$];

    always #2 clk = ~clk;

    cmd_frame_rx i_cmd_frame_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_opcode(cmd_opcode), .cmd_len(cmd_len), .cmd_rd_idx(cmd_rd_idx),
        .cmd_rd_data(cmd_rd_data), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .rsp_read(rsp_read)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: sends one command, queues expectations, injects a stray word
    // while busy, then waits for the response to be consumed.
    task automatic send_cmd(input logic [3:0] op, input int len);
        int nargs;
        int target;
        bit ack;
        nargs  = (len == 0) ? 0 : len - 1;
        ack    = (op < 4'd8) && (len >= 1) && (len <= 65);
        target = rsp_seen + 1;
        exp_rsp_q.push_back({ack ? 4'h1 : 4'h2, op, 8'h00});
        if (ack) exp_hdr_q.push_back({op, 12'(len)});
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = {op, 12'(len)};
        for (int k = 0; k < nargs; k++) begin
            @(negedge clk);
            in_word = 16'hA000 ^ 16'(k * 37) ^ {12'h0, op};
            if (ack) exp_data_q.push_back(in_word);
        end
        @(negedge clk);
        // R9: busy right after the last word; this stray header must be ignored
        check(busy == 1'b1, "R9 busy", 32'(busy), 32'd1);
        in_word = 16'h1003;
        @(negedge clk);
        in_valid = 1'b0;
        wait (rsp_seen == target);
    endtask

    // Monitor: compares offered commands and responses with the queues.
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                logic [15:0] h;
                if (exp_hdr_q.size() == 0) begin
                    check(1'b0, "R6 unexpected command", 32'(cmd_opcode), 32'hFFFF);
                    h = {cmd_opcode, cmd_len};
                end else begin
                    h = exp_hdr_q.pop_front();
                end
                // R2
                check(cmd_opcode == h[15:12], "R2 opcode", 32'(cmd_opcode), 32'(h[15:12]));
                // R3
                check(cmd_len == h[11:0], "R3 length", 32'(cmd_len), 32'(h[11:0]));
                for (int k = 0; k + 1 < int'(h[11:0]); k++) begin
                    logic [15:0] d;
                    d = (exp_data_q.size() != 0) ? exp_data_q.pop_front() : 16'hXXXX;
                    cmd_rd_idx = 6'(k);
                    #0.1;
                    // R4
                    check(cmd_rd_data === d, "R4 argument", 32'(cmd_rd_data), 32'(d));
                end
                repeat (2) @(negedge clk);
                // R11
                check(cmd_valid && cmd_opcode == h[15:12], "R11 hold", 32'(cmd_valid), 32'd1);
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
            end else if (rsp_valid) begin
                logic [15:0] r;
                r = (exp_rsp_q.size() != 0) ? exp_rsp_q.pop_front() : 16'hDEAD;
                // R5 R6 R7 R8 R10
                check(rsp_word == r, "R5/R6/R7/R8 response", 32'(rsp_word), 32'(r));
                rsp_seen++;
                rsp_read = 1'b1;
                @(negedge clk);
                rsp_read = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy && !cmd_valid && !rsp_valid, "R1 reset state",
              {29'd0, busy, cmd_valid, rsp_valid}, 32'd0);

        send_cmd(4'h3, 1);     // R3 header only
        send_cmd(4'h5, 4);     // R3 R4 three arguments
        send_cmd(4'h0, 65);    // R8 buffer exactly full
        send_cmd(4'h1, 66);    // R8 oversize
        send_cmd(4'h9, 3);     // R6 unsupported with arguments
        send_cmd(4'hF, 1);     // R6 unsupported header only
        send_cmd(4'h2, 0);     // R7 zero length
        send_cmd(4'h7, 2);     // R7 next word after NACK is a header

        // R1: reset in the middle of a command
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 16'h4005;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !cmd_valid && !rsp_valid, "R1 mid-command reset",
              {29'd0, busy, cmd_valid, rsp_valid}, 32'd0);
        send_cmd(4'h6, 3);     // R1 fresh header accepted after reset

        repeat (4) @(negedge clk);
        check(exp_rsp_q.size() == 0 && exp_hdr_q.size() == 0, "R3 queues drained",
              32'(exp_rsp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule